// File: doc/BRIEF.md
# Dual-Structure LFSR Sequence Generator

The block is a 16-bit pseudo-random sequence source built on the maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1. It has 65535 states. A static parameter selects how the feedback is wired. The external-XOR form computes one feedback bit from several taps and shifts it into the top stage. The internal-XOR form shifts the register and flips a fixed set of stages whenever the bit leaving the bottom stage is 1. Both forms present the same ports. Their serial bit streams obey the same linear recurrence, so a consumer of the serial output cannot tell which form is in use.

A second static option swaps XOR feedback for XNOR feedback. With XOR feedback the state that never advances is all zeros. With XNOR feedback it is all ones. The block watches for that stuck state. A seed load can bring it in. When that happens, a lock-up flag rises for one cycle, and the next enabled clock replaces the state with the recovery value 0xACE1.

In use, a seed is loaded once and the enable is then pulsed whenever a new value is wanted. The seed strobe always wins over the enable.

Top module: `prng16_core`

## Requirements
- R1: While the synchronous reset is high, the state is set to 0xACE1 and the lock-up flag is cleared. Both are visible in the cycle after the reset edge.
- R2: When the seed strobe is high on a clock edge, the seed value appears on the state output after that edge. This holds whatever the enable does.
- R3: With no seed strobe and the enable low, the state does not change.
- R4: External-XOR form (state bit 0 is the rightmost stage): an enabled step shifts the state right by one. The new bit 15 is the XOR of bits 0, 2, 3 and 5. From 0xACE1 the next state is 0x5670.
- R5: Internal-XOR form: an enabled step shifts the state right by one. If the bit shifted out was 1, the result is XORed with 0xB400. From 0xACE1 the next state is 0xE270.
- R6: XNOR option: the external form inverts its feedback bit. In the internal form, stages 13, 12 and 10 take the XNOR of the shifted bit and the outgoing bit, and stage 15 takes the outgoing bit. From 0xACE1 both forms step to 0xD670.
- R7: The serial output equals state bit 0. Over any run of enabled steps, each serial bit u[t] equals u[t-16] ^ u[t-14] ^ u[t-13] ^ u[t-11] in both forms. In XNOR mode the result of that XOR is inverted.
- R8: After a seed of 0xACE1 is loaded, the state returns to 0xACE1 after exactly 65535 enabled steps and at no earlier step.
- R9: An enabled step from a legal state never produces the illegal state. The illegal state is 0x0000 with XOR feedback and 0xFFFF with XNOR feedback.
- R10: The lock-up flag is high for exactly the first cycle in which the state holds the illegal value. It never stays high for two consecutive cycles, and it is never high while the state is legal.
- R11: An enabled clock with no seed strobe, while the state is illegal, sets the state to 0xACE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| step_en_i | input | 1 | Advance the sequence by one step |
| seed_load_i | input | 1 | Load seed_i into the state; has priority over step_en_i |
| seed_i | input | 16 | Seed value |
| state_o | output | 16 | Current register state |
| serial_o | output | 1 | Rightmost stage of the state |
| lockup_o | output | 1 | One-cycle pulse on entering the illegal state |

## Verification
Some behaviours are checked by assertions on every cycle:
- seed capture;
- holding while disabled;
- the shift-and-toggle relation of the selected form;
- never stepping into the illegal state;
- the single-cycle lock-up pulse and its tie to the illegal value;
- forced recovery.

Other behaviours only the bench's scenarios can show. These are the stated first values after 0xACE1 for all four variants, the exact 65535-step period with no early return, and the serial recurrence shared by both forms. Each of these needs either a known start point or a long observed history.

// File: rtl/prng_pkg.sv
package prng_pkg;

    // Feedback wiring of the shift register.
    typedef enum logic {
        FB_EXTERNAL = 1'b0,
        FB_INTERNAL = 1'b1
    } fb_form_e;

    // What the register does on the coming edge.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_LOAD    = 2'd1,
        ACT_STEP    = 2'd2,
        ACT_RECOVER = 2'd3
    } step_act_e;

    // Mirror the low w bits of v (bit i moves to bit w-1-i).
    function automatic logic [63:0] reverse_bits(input logic [63:0] v, input int w);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w) begin
                r[w - 1 - i] = v[i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/prng_step_ext.sv
// Many-to-one next-state function: one feedback bit from all taps enters the top stage.
module prng_step_ext #(
    parameter int                WIDTH   = 16,
    parameter logic [WIDTH-1:0]  TAP_SEL = 16'h002D,
    parameter bit                INVERT  = 1'b0
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] next_o
);

    logic fb_bit;

    always_comb begin
        fb_bit = (^(state_i & TAP_SEL)) ^ INVERT;
        next_o = {fb_bit, state_i[WIDTH-1:1]};
    end

endmodule

// File: rtl/prng_step_int.sv
// One-to-many next-state function: the outgoing bit is folded into every tapped stage.
module prng_step_int #(
    parameter int                WIDTH       = 16,
    parameter logic [WIDTH-1:0]  TOGGLE_MASK = 16'hB400,
    parameter bit                INVERT      = 1'b0
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] next_o
);

    logic             out_bit;
    logic [WIDTH:0]   shift_src;

    assign out_bit   = state_i[0];
    assign shift_src = {INVERT, state_i};

    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
        if (TOGGLE_MASK[k] && INVERT) begin : g_tap_xn
            assign next_o[k] = ~(shift_src[k+1] ^ out_bit);
        end else if (TOGGLE_MASK[k]) begin : g_tap_x
            assign next_o[k] = shift_src[k+1] ^ out_bit;
        end else begin : g_pass
            assign next_o[k] = shift_src[k+1];
        end
    end

endmodule

// File: rtl/prng_illegal_det.sv
// Flags the one state that the chosen feedback polarity cannot leave.
module prng_illegal_det #(
    parameter int WIDTH  = 16,
    parameter bit INVERT = 1'b0
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             illegal_o
);

    if (INVERT) begin : g_ones
        assign illegal_o = &value_i;
    end else begin : g_zeros
        assign illegal_o = ~|value_i;
    end

endmodule

// File: rtl/prng16_core.sv
module prng16_core #(
    parameter int                  WIDTH         = 16,
    parameter prng_pkg::fb_form_e  FORM          = prng_pkg::FB_EXTERNAL,
    parameter bit                  INVERT        = 1'b0,
    parameter logic [WIDTH-1:0]    TAP_MASK      = 16'hB400,
    parameter logic [WIDTH-1:0]    RECOVERY_SEED = 16'hACE1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_en_i,
    input  logic             seed_load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] state_o,
    output logic             serial_o,
    output logic             lockup_o
);

    import prng_pkg::*;

    // Tap select of the external form is the mirror of the internal toggle mask.
    localparam logic [WIDTH-1:0] EXT_TAPS = WIDTH'(reverse_bits(64'(TAP_MASK), WIDTH));

    typedef struct packed {
        logic [WIDTH-1:0] state;
        logic             lock;
    } core_reg_t;

    localparam core_reg_t RESET_VAL = '{state: RECOVERY_SEED, lock: 1'b0};

    core_reg_t        reg_d, reg_q;
    step_act_e        act;
    logic [WIDTH-1:0] step_val;
    logic             cur_illegal;
    logic             seed_illegal;

    if (FORM == FB_INTERNAL) begin : g_int
        prng_step_int #(
            .WIDTH       (WIDTH),
            .TOGGLE_MASK (TAP_MASK),
            .INVERT      (INVERT)
        ) i_step (
            .state_i (reg_q.state),
            .next_o  (step_val)
        );
    end else begin : g_ext
        prng_step_ext #(
            .WIDTH   (WIDTH),
            .TAP_SEL (EXT_TAPS),
            .INVERT  (INVERT)
        ) i_step (
            .state_i (reg_q.state),
            .next_o  (step_val)
        );
    end

    prng_illegal_det #(
        .WIDTH  (WIDTH),
        .INVERT (INVERT)
    ) i_det_state (
        .value_i   (reg_q.state),
        .illegal_o (cur_illegal)
    );

    prng_illegal_det #(
        .WIDTH  (WIDTH),
        .INVERT (INVERT)
    ) i_det_seed (
        .value_i   (seed_i),
        .illegal_o (seed_illegal)
    );

    always_comb begin
        if (seed_load_i) begin
            act = ACT_LOAD;
        end else if (step_en_i) begin
            act = cur_illegal ? ACT_RECOVER : ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end

        reg_d = reg_q;
        unique case (act)
            ACT_LOAD:    reg_d.state = seed_i;
            ACT_STEP:    reg_d.state = step_val;
            ACT_RECOVER: reg_d.state = RECOVERY_SEED;
            default:     reg_d.state = reg_q.state;
        endcase

        // Legal steps never reach the stuck value, so only a load can enter it.
        reg_d.lock = seed_load_i && seed_illegal && !cur_illegal;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            reg_q <= RESET_VAL;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign state_o  = reg_q.state;
    assign serial_o = reg_q.state[0];
    assign lockup_o = reg_q.lock;

endmodule

// File: rtl/prng16_core_chk.sv
module prng16_core_chk #(
    parameter int                  WIDTH         = 16,
    parameter prng_pkg::fb_form_e  FORM          = prng_pkg::FB_EXTERNAL,
    parameter bit                  INVERT        = 1'b0,
    parameter logic [WIDTH-1:0]    TAP_MASK      = 16'hB400,
    parameter logic [WIDTH-1:0]    RECOVERY_SEED = 16'hACE1
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             step_en_i,
    input logic             seed_load_i,
    input logic [WIDTH-1:0] seed_i,
    input logic [WIDTH-1:0] state_o,
    input logic             lockup_o
);

    localparam logic [WIDTH-1:0] ILLEGAL  = {WIDTH{INVERT}};
    localparam logic [WIDTH-1:0] EXT_TAPS =
        WIDTH'(prng_pkg::reverse_bits(64'(TAP_MASK), WIDTH));

    // R2: the strobe captures the seed on the next edge
    a_r2_seed_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        seed_load_i |=> state_o == $past(seed_i));

    // R3: no strobe and no enable keeps the state
    a_r3_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_load_i && !step_en_i) |=> $stable(state_o));

    if (FORM == prng_pkg::FB_EXTERNAL) begin : g_ext_chk
        // R4, R6: shift right, feedback into the top stage
        a_r4_ext_shift: assert property (@(posedge clk_i) disable iff (rst_i)
            (!seed_load_i && step_en_i && state_o != ILLEGAL) |=>
            (state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])) &&
            (state_o[WIDTH-1] == ($past(^(state_o & EXT_TAPS)) ^ INVERT)));
    end else begin : g_int_chk
        // R5, R6: shifted value differs only at tapped stages, and only when the outgoing bit asks
        a_r5_int_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
            (!seed_load_i && step_en_i && state_o != ILLEGAL) |=>
            ((state_o ^ {1'(INVERT), $past(state_o[WIDTH-1:1])}) ==
             (($past(state_o[0]) ^ INVERT) ? TAP_MASK : '0)));
    end

    // R9: stepping never lands on the stuck value
    a_r9_no_illegal_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_load_i && step_en_i) |=> state_o != ILLEGAL);

    // R10: lock-up pulse lasts one cycle
    a_r10_lock_single: assert property (@(posedge clk_i) disable iff (rst_i)
        lockup_o |=> !lockup_o);

    // R10: the pulse only accompanies the stuck value
    a_r10_lock_illegal: assert property (@(posedge clk_i) disable iff (rst_i)
        lockup_o |-> state_o == ILLEGAL);

    // R11: enabled clock while stuck restores the recovery value
    a_r11_recover: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_load_i && step_en_i && state_o == ILLEGAL) |=> state_o == RECOVERY_SEED);

endmodule

bind prng16_core prng16_core_chk #(
    .WIDTH         (WIDTH),
    .FORM          (FORM),
    .INVERT        (INVERT),
    .TAP_MASK      (TAP_MASK),
    .RECOVERY_SEED (RECOVERY_SEED)
) i_prng16_core_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .step_en_i   (step_en_i),
    .seed_load_i (seed_load_i),
    .seed_i      (seed_i),
    .state_o     (state_o),
    .lockup_o    (lockup_o)
);

// File: tb/test_prng16_core.sv
`timescale 1ns/1ps
module test_prng16_core;

    localparam logic [15:0] SEED0   = 16'hACE1;
    localparam int          WD_LIMIT = 150000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        ld  = 1'b0;
    logic [15:0] sd  = '0;

    // Lanes: 0 external/XOR, 1 internal/XOR, 2 external/XNOR, 3 internal/XNOR
    logic [3:0][15:0] st_w;
    logic [3:0]       ser_w;
    logic [3:0]       lk_w;

    prng16_core i_prng16_core (
        .clk_i(clk), .rst_i(rst), .step_en_i(en), .seed_load_i(ld), .seed_i(sd),
        .state_o(st_w[0]), .serial_o(ser_w[0]), .lockup_o(lk_w[0]));

    prng16_core #(.FORM(prng_pkg::FB_INTERNAL)) i_prng16_core_int (
        .clk_i(clk), .rst_i(rst), .step_en_i(en), .seed_load_i(ld), .seed_i(sd),
        .state_o(st_w[1]), .serial_o(ser_w[1]), .lockup_o(lk_w[1]));

    prng16_core #(.INVERT(1'b1)) i_prng16_core_xn (
        .clk_i(clk), .rst_i(rst), .step_en_i(en), .seed_load_i(ld), .seed_i(sd),
        .state_o(st_w[2]), .serial_o(ser_w[2]), .lockup_o(lk_w[2]));

    prng16_core #(.FORM(prng_pkg::FB_INTERNAL), .INVERT(1'b1)) i_prng16_core_int_xn (
        .clk_i(clk), .rst_i(rst), .step_en_i(en), .seed_load_i(ld), .seed_i(sd),
        .state_o(st_w[3]), .serial_o(ser_w[3]), .lockup_o(lk_w[3]));

    typedef struct {
        logic [3:0][15:0] st;
        logic [3:0]       lk;
        string            tag;
    } exp_t;

    exp_t             sbq[$];
    logic [3:0][15:0] m_st;
    logic [3:0]       m_lk;
    int               n_checks = 0;
    int               n_errors = 0;
    bit               done     = 1'b0;
    int               cyc      = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference next state written from the requirement text; XNOR as complement of the XOR map.
    function automatic logic [15:0] model_next(input logic [15:0] s, input bit gal, input bit xn);
        logic [15:0] t, r;
        t = xn ? ~s : s;
        if (!gal) begin
            r = {t[0] ^ t[2] ^ t[3] ^ t[5], t[15:1]};
        end else begin
            r = t >> 1;
            if (t[0]) r = r ^ 16'hB400;
        end
        return xn ? ~r : r;
    endfunction

    // Driver: called just after a falling edge; drives, predicts, pushes after the rising edge.
    task automatic step(input bit r, input bit l, input bit e, input logic [15:0] s,
                        input string tag);
        exp_t it;
        rst = r; ld = l; en = e; sd = s;
        for (int i = 0; i < 4; i++) begin
            logic [15:0] ill, nst;
            ill = (i >= 2) ? 16'hFFFF : 16'h0000;
            if (r) begin
                m_st[i] = SEED0;
                m_lk[i] = 1'b0;
            end else begin
                if (l)       nst = s;
                else if (e)  nst = (m_st[i] == ill) ? SEED0 : model_next(m_st[i], i[0], i >= 2);
                else         nst = m_st[i];
                m_lk[i] = (nst == ill) && (m_st[i] != ill);
                m_st[i] = nst;
            end
        end
        it.st = m_st; it.lk = m_lk; it.tag = tag;
        @(posedge clk);
        sbq.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compares every lane against the scoreboard away from the active edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            for (int i = 0; i < 4; i++) begin
                chk(st_w[i] === e.st[i], e.tag, $sformatf("lane%0d state", i), st_w[i], e.st[i]);
                chk(ser_w[i] === e.st[i][0], "R7", $sformatf("lane%0d serial", i),
                    16'(ser_w[i]), 16'(e.st[i][0]));
                chk(lk_w[i] === e.lk[i], e.tag, $sformatf("lane%0d lockup", i),
                    16'(lk_w[i]), 16'(e.lk[i]));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [3:0][15:0] saved;
        logic [16:0]      win[4];
        int               early[4];
        int               rec_bad[4];
        int               ill_seen[4];

        @(negedge clk);
        step(1, 0, 0, 16'h0, "R1");
        for (int i = 0; i < 4; i++) begin
            chk(st_w[i] == SEED0, "R1", "reset state", st_w[i], SEED0);
            chk(lk_w[i] == 1'b0, "R1", "reset lockup", 16'(lk_w[i]), 16'h0);
        end

        step(0, 1, 0, SEED0, "R2");
        step(0, 0, 1, 16'h0, "R4");
        chk(st_w[0] == 16'h5670, "R4", "external step from ACE1", st_w[0], 16'h5670);
        chk(st_w[1] == 16'hE270, "R5", "internal step from ACE1", st_w[1], 16'hE270);
        chk(st_w[2] == 16'hD670, "R6", "external xnor step", st_w[2], 16'hD670);
        chk(st_w[3] == 16'hD670, "R6", "internal xnor step", st_w[3], 16'hD670);

        for (int k = 0; k < 5; k++) step(0, 0, 1, 16'h0, "R5");

        saved = st_w;
        for (int k = 0; k < 4; k++) step(0, 0, 0, 16'h0, "R3");
        for (int i = 0; i < 4; i++)
            chk(st_w[i] == saved[i], "R3", "hold while disabled", st_w[i], saved[i]);

        step(0, 1, 1, 16'h1234, "R2");
        for (int i = 0; i < 4; i++)
            chk(st_w[i] == 16'h1234, "R2", "load beats enable", st_w[i], 16'h1234);

        step(0, 1, 0, 16'h0000, "R10");
        chk(lk_w == 4'b0011, "R10", "lockup on zero load", 16'(lk_w), 16'h0003);
        step(0, 0, 0, 16'h0, "R10");
        chk(lk_w == 4'b0000, "R10", "lockup single cycle", 16'(lk_w), 16'h0000);
        chk(st_w[0] == 16'h0000, "R3", "stuck state held", st_w[0], 16'h0000);
        step(0, 0, 1, 16'h0, "R11");
        chk(st_w[0] == SEED0, "R11", "external recovery", st_w[0], SEED0);
        chk(st_w[1] == SEED0, "R11", "internal recovery", st_w[1], SEED0);
        chk(st_w[2] == 16'h8000, "R6", "xnor leaves zero", st_w[2], 16'h8000);

        step(0, 1, 0, 16'hFFFF, "R10");
        chk(lk_w == 4'b1100, "R10", "lockup on ones load", 16'(lk_w), 16'h000C);
        step(0, 0, 1, 16'h0, "R11");
        chk(st_w[2] == SEED0, "R11", "external xnor recovery", st_w[2], SEED0);
        chk(st_w[3] == SEED0, "R11", "internal xnor recovery", st_w[3], SEED0);

        // Full period run
        step(0, 1, 0, SEED0, "R8");
        for (int i = 0; i < 4; i++) begin
            win[i] = {16'h0, ser_w[i]};
            early[i] = 0; rec_bad[i] = 0; ill_seen[i] = 0;
        end
        for (int n = 1; n <= 65535; n++) begin
            step(0, 0, 1, 16'h0, "R8");
            for (int i = 0; i < 4; i++) begin
                bit xn;
                xn = (i >= 2);
                win[i] = {win[i][15:0], ser_w[i]};
                if (n >= 16 && win[i][0] !== (win[i][16] ^ win[i][14] ^ win[i][13] ^ win[i][11] ^ xn))
                    rec_bad[i]++;
                if (n < 65535 && st_w[i] == SEED0) early[i]++;
                if (st_w[i] == (xn ? 16'hFFFF : 16'h0000)) ill_seen[i]++;
            end
        end
        for (int i = 0; i < 4; i++) begin
            chk(st_w[i] == SEED0, "R8", $sformatf("lane%0d seed after 65535", i), st_w[i], SEED0);
            chk(early[i] == 0, "R8", $sformatf("lane%0d early return", i), 16'(early[i]), 16'h0);
            chk(rec_bad[i] == 0, "R7", $sformatf("lane%0d serial recurrence", i), 16'(rec_bad[i]), 16'h0);
            chk(ill_seen[i] == 0, "R9", $sformatf("lane%0d illegal reached", i), 16'(ill_seen[i]), 16'h0);
        end

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule